// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital half of a 16-bit successive-approximation converter. On a convert request it places a trial code on a DAC port, waits a fixed settling interval, samples a one-bit comparator input, and keeps or clears the trial bit. It then moves to the next lower bit. A status output stays high for the whole conversion. At completion a one-cycle done pulse carries the final word to an external output latch.

Each bit is also sent out on a serial data pin as soon as it is decided, most significant bit first. A strobe that idles high falls a fixed number of clocks after each serial update, so a shift register on the far side of an isolation barrier can capture the stream. A convert request is a falling edge of the active-low write strobe while the active-low chip select is low. Requests that arrive during a conversion are ignored. If the request is still held low when a conversion ends, the next conversion starts at once. The active-low reset aborts any conversion.

Top module: `sar_seq_ctrl`

## Requirements
- R1: The word is WIDTH (16) bits wide and is decided from the MSB down, one bit every SETTLE_CYC (4) clocks. During a step the trial bit is 1 on `dac_code`. The bit is kept when `cmp_ge` is 1 in the last clock of the step, and cleared otherwise. The first trial code is 0x8000.
- R2: A conversion starts when `wr_n` was sampled high in the previous clock and is sampled low now, with `cs_n` low. `busy` rises on that clock edge. `wr_n` that is already low when `cs_n` falls starts nothing.
- R3: `busy` stays high for exactly WIDTH*SETTLE_CYC (64) clocks for each conversion.
- R4: A request made while `busy` is high is ignored. The conversion length and the result are unchanged.
- R5: If `cs_n` and `wr_n` are both low in the final clock of a conversion, a new conversion starts at once. `busy` stays high through the `done` cycle.
- R6: `ser_dat` takes each bit on the clock edge where that bit is decided, MSB first, and holds it until the next decision.
- R7: `ser_stb` idles high. It falls STB_DLY (2) clocks after each `ser_dat` update and stays low for one clock. This gives exactly WIDTH falling edges per conversion.
- R8: Asserting `rst_n` low at once forces `busy`, `done`, `dac_code`, `result` and `ser_dat` to 0 and `ser_stb` to 1, aborting any conversion.
- R9: `done` is high for one clock, in the first clock where `busy` has fallen (or, on a retrigger, would have fallen). In that clock `result` holds the final word. `result` keeps that value until the next completion.
- R10: A `wr_n` falling edge while `cs_n` is high starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low convert strobe; its falling edge requests a conversion |
| cmp_ge | input | 1 | Comparator: 1 when the analog input is at or above the DAC output |
| dac_code | output | 16 | Trial code for the DAC |
| busy | output | 1 | High while a conversion is in progress |
| ser_dat | output | 1 | Serial data, each decided bit, MSB first, NRZ |
| ser_stb | output | 1 | Serial strobe, idles high, one falling edge per bit |
| done | output | 1 | One-clock pulse at completion |
| result | output | 16 | Final word, valid with `done` and held afterwards |

## Verification
A wrong step counter or bit index shows within one conversion. `busy` runs longer or shorter than 64 clocks, the strobe falls at the wrong clock offsets, or the word arrives shifted. A corrupted SAR bit shows as a `result` and a serial word that differ from the code the comparator model holds. It also shows on `dac_code` within four clocks of the first decision. Errors in start detection show as a conversion that starts without a falling edge or restarts mid-flight. They are visible on `busy` one clock after the offending input.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } conv_state_t;
endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
  import sar_seq_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int SETTLE_CYC = 4,
  localparam int IDX_W     = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  output logic             busy_o,
  output logic             dec_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(WIDTH - 1);

  conv_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign busy_o = (state_q == ST_CONV);
  assign dec_o  = busy_o && (cnt_q == CNT_LAST);
  assign last_o = dec_o && (idx_q == '0);
  assign idx_o  = idx_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    if (state_q == ST_CONV) begin
      if (cnt_q == CNT_LAST) begin
        cnt_d = '0;
        if (idx_q == '0) state_d = ST_IDLE;
        else             idx_d   = idx_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (launch) begin
      state_d = ST_CONV;
      cnt_d   = '0;
      idx_d   = IDX_TOP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !last_o |=> busy_o); // R3
  AST_IDX_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !dec_o |=> $stable(idx_q)); // R4
endmodule

// File: rtl/sar_seq_reg.sv
module sar_seq_reg #(
  parameter int WIDTH  = 16,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             dec,
  input  logic             last,
  input  logic [IDX_W-1:0] idx,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o,
  output logic             bit_o
);
  localparam logic [WIDTH-1:0] TRIAL_MSB = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] sar_q, sar_d;
  logic [WIDTH-1:0] decided;
  logic [WIDTH-1:0] res_q;
  logic             done_q;

  always_comb begin
    decided      = sar_q;
    decided[idx] = cmp_ge;
  end

  always_comb begin
    sar_d = sar_q;
    if (launch) begin
      sar_d = TRIAL_MSB;
    end else if (dec) begin
      sar_d = decided;
      if (idx != '0) sar_d[idx - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sar_q  <= sar_d;
      done_q <= last;
      if (last) res_q <= decided;
    end
  end

  assign dac_code_o = sar_q;
  assign result_o   = res_q;
  assign done_o     = done_q;
  assign bit_o      = cmp_ge;

  AST_SAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dec && !launch |=> $stable(sar_q)); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
endmodule

// File: rtl/sar_seq_serial.sv
module sar_seq_serial #(
  parameter int STB_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dec,
  input  logic bit_i,
  output logic ser_dat_o,
  output logic ser_stb_o
);
  localparam int DLY_W = $clog2(STB_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(STB_DLY);
  localparam logic [DLY_W-1:0] DLY_ONE  = DLY_W'(1);

  logic [DLY_W-1:0] dly_q, dly_d;
  logic             dat_q, stb_q, stb_d;

  always_comb begin
    dly_d = dly_q;
    if (dec)              dly_d = DLY_LOAD;
    else if (dly_q != '0) dly_d = dly_q - 1'b1;
    stb_d = (dly_q != DLY_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      dat_q <= 1'b0;
      stb_q <= 1'b1;
    end else begin
      dly_q <= dly_d;
      stb_q <= stb_d;
      if (dec) dat_q <= bit_i;
    end
  end

  assign ser_dat_o = dat_q;
  assign ser_stb_o = stb_q;

  AST_STB_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |=> stb_q); // R7
  AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dec |=> $stable(dat_q)); // R6
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int WIDTH      = 16,
  parameter int SETTLE_CYC = 4,
  parameter int STB_DLY    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] dac_code,
  output logic             busy,
  output logic             ser_dat,
  output logic             ser_stb,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  localparam int IDX_W = $clog2(WIDTH);

  logic             wr_prev_q;
  logic             req_lvl, req_edge, launch;
  logic             dec, last, bit_val;
  logic [IDX_W-1:0] idx;

  // Previous strobe sample resets low: a strobe already low out of reset is no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev_q <= 1'b0;
    else        wr_prev_q <= wr_n;
  end

  assign req_lvl  = !cs_n && !wr_n;
  assign req_edge = req_lvl && wr_prev_q;
  assign launch   = (!busy && req_edge) || (last && req_lvl);

  sar_seq_timer #(.WIDTH(WIDTH), .SETTLE_CYC(SETTLE_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .busy_o(busy), .dec_o(dec), .last_o(last), .idx_o(idx)
  );

  sar_seq_reg #(.WIDTH(WIDTH)) reg_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .dec(dec), .last(last),
    .idx(idx), .cmp_ge(cmp_ge), .dac_code_o(dac_code), .result_o(result),
    .done_o(done), .bit_o(bit_val)
  );

  sar_seq_serial #(.STB_DLY(STB_DLY)) ser_i (
    .clk(clk), .rst_n(rst_n), .dec(dec), .bit_i(bit_val),
    .ser_dat_o(ser_dat), .ser_stb_o(ser_stb)
  );

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cs_n && !wr_n)); // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R9
  AST_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    last && req_lvl |=> busy); // R5
endmodule

// File: tb/sar_seq_ctrl_tb_top.sv
module sar_seq_ctrl_tb_top;
  localparam int WIDTH  = 16;
  localparam int SETTLE = 4;
  localparam int STB    = 2;
  localparam int CONV_CYC = WIDTH * SETTLE;

  logic clk, rst_n, cs_n, wr_n, cmp_ge;
  logic [WIDTH-1:0] dac_code, result, vin_r;
  logic busy, ser_dat, ser_stb, done;

  int n_chk, n_fail;
  int cyc, rise_cyc, busy_cnt, stb_cnt, stb_bad, done_cnt;
  logic [31:0] ser_word;
  logic [WIDTH-1:0] res_cap;
  logic busy_p, stb_p;

  // {analog input code, expected word}
  localparam logic [31:0] VECS [8] = '{
    {16'h0000, 16'h0000}, {16'hFFFF, 16'hFFFF}, {16'h8000, 16'h8000},
    {16'h7FFF, 16'h7FFF}, {16'hA5A5, 16'hA5A5}, {16'h0001, 16'h0001},
    {16'hFFFE, 16'hFFFE}, {16'h1234, 16'h1234}
  };

  sar_seq_ctrl #(.WIDTH(WIDTH), .SETTLE_CYC(SETTLE), .STB_DLY(STB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .cmp_ge(cmp_ge),
    .dac_code(dac_code), .busy(busy), .ser_dat(ser_dat), .ser_stb(ser_stb),
    .done(done), .result(result)
  );

  assign cmp_ge = (vin_r >= dac_code);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cnt++;
    if (busy && !busy_p) rise_cyc = cyc;
    if (stb_p && !ser_stb) begin
      stb_cnt++;
      ser_word = {ser_word[30:0], ser_dat};
      if (cyc - rise_cyc != SETTLE * stb_cnt + STB) stb_bad++;
    end
    if (done) begin
      done_cnt++;
      res_cap = result;
    end
    busy_p = busy;
    stb_p  = ser_stb;
  end

  task automatic clear_mon();
    busy_cnt = 0; stb_cnt = 0; stb_bad = 0; done_cnt = 0; ser_word = '0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4 * CONV_CYC; i++) begin
      @(posedge clk); #1;
      if (done) break;
    end
  endtask

  task automatic start_conv(input logic [WIDTH-1:0] vin);
    @(posedge clk); #1;
    clear_mon();
    vin_r = vin; cs_n = 1'b0; wr_n = 1'b0;
    @(posedge clk); #1;
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; rise_cyc = 0;
    busy_p = 1'b0; stb_p = 1'b1; res_cap = '0;
    clear_mon();
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; vin_r = '0;
    repeat (3) @(posedge clk); #1;
    // R8 reset state
    chk(busy == 0 && done == 0, "R8 busy/done in reset", {busy, done}, 0);
    chk(dac_code == 0 && result == 0, "R8 dac/result in reset", {dac_code, result}, 0);
    chk(ser_stb == 1 && ser_dat == 0, "R8 serial pins in reset", {ser_stb, ser_dat}, 2);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // Vector table: R1 R3 R6 R7 R9
    for (int i = 0; i < 8; i++) begin
      start_conv(VECS[i][31:16]);
      wait_done();
      repeat (STB + 2) @(posedge clk); #1;
      chk(res_cap == VECS[i][15:0], "R1 result word", res_cap, VECS[i][15:0]);
      chk(ser_word[15:0] == VECS[i][15:0], "R6 serial word", ser_word[15:0], VECS[i][15:0]);
      chk(busy_cnt == CONV_CYC, "R3 busy length", busy_cnt, CONV_CYC);
      chk(stb_cnt == WIDTH, "R7 strobe falls", stb_cnt, WIDTH);
      chk(stb_bad == 0, "R7 strobe timing", stb_bad, 0);
      chk(done_cnt == 1, "R9 done pulse width", done_cnt, 1);
    end

    // R1 R2: first trial code and first decision
    @(posedge clk); #1;
    clear_mon(); vin_r = 16'hA5A5; cs_n = 1'b0; wr_n = 1'b0;
    chk(busy == 0, "R2 busy before edge", busy, 0);
    @(posedge clk); #1;
    wr_n = 1'b1; cs_n = 1'b1;
    chk(busy == 1, "R2 busy after edge", busy, 1);
    chk(dac_code == 16'h8000, "R1 first trial", dac_code, 16'h8000);
    repeat (SETTLE) @(posedge clk); #1;
    chk(dac_code == 16'hC000, "R1 second trial", dac_code, 16'hC000);
    wait_done();
    chk(result == 16'hA5A5, "R9 result with done", result, 16'hA5A5);
    repeat (4) @(posedge clk); #1;

    // R10: edge with chip select high
    wr_n = 1'b0;
    repeat (10) @(posedge clk); #1;
    chk(busy == 0, "R10 no start with cs_n high", busy, 0);
    // R2: chip select falls while strobe already low
    cs_n = 1'b0;
    repeat (10) @(posedge clk); #1;
    chk(busy == 0, "R2 no start without wr_n edge", busy, 0);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(posedge clk);

    // R4: request mid-conversion is ignored
    start_conv(16'h3C3C);
    repeat (20) @(posedge clk); #1;
    cs_n = 1'b0;
    @(posedge clk); #1; wr_n = 1'b0;
    @(posedge clk); #1; wr_n = 1'b1; cs_n = 1'b1;
    wait_done();
    repeat (STB + 2) @(posedge clk); #1;
    chk(busy_cnt == CONV_CYC, "R4 length unchanged", busy_cnt, CONV_CYC);
    chk(res_cap == 16'h3C3C, "R4 result unchanged", res_cap, 16'h3C3C);
    chk(done_cnt == 1, "R4 single completion", done_cnt, 1);

    // R5: retrigger while request held
    @(posedge clk); #1;
    clear_mon(); vin_r = 16'h1357; cs_n = 1'b0; wr_n = 1'b0;
    wait_done();
    chk(result == 16'h1357, "R5 first word", result, 16'h1357);
    chk(busy == 1, "R5 busy held at completion", busy, 1);
    vin_r = 16'h9ABC; cs_n = 1'b1; wr_n = 1'b1;
    wait_done();
    repeat (STB + 2) @(posedge clk); #1;
    chk(res_cap == 16'h9ABC, "R5 second word", res_cap, 16'h9ABC);
    chk(busy_cnt == 2 * CONV_CYC, "R5 back-to-back length", busy_cnt, 2 * CONV_CYC);
    chk(ser_word == 32'h13579ABC, "R6 two serial words", ser_word, 32'h13579ABC);

    // R9: result held until the next completion
    start_conv(16'h0F0F);
    repeat (10) @(posedge clk); #1;
    chk(result == 16'h9ABC, "R9 result held mid-conversion", result, 16'h9ABC);
    wait_done();
    chk(result == 16'h0F0F, "R9 new result", result, 16'h0F0F);
    repeat (4) @(posedge clk);

    // R8: abort mid-conversion
    start_conv(16'hFFFF);
    repeat (30) @(posedge clk); #1;
    rst_n = 1'b0;
    #1;
    chk(busy == 0 && done == 0, "R8 abort busy/done", {busy, done}, 0);
    chk(dac_code == 0 && result == 0, "R8 abort dac/result", {dac_code, result}, 0);
    chk(ser_stb == 1 && ser_dat == 0, "R8 abort serial", {ser_stb, ser_dat}, 2);
    @(posedge clk); #1;
    rst_n = 1'b1;
    clear_mon();
    repeat (CONV_CYC + 10) @(posedge clk); #1;
    chk(done_cnt == 0 && busy_cnt == 0, "R8 no completion after abort",
        {done_cnt[15:0], busy_cnt[15:0]}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule